// File: doc/BRIEF.md
# Serial Programming-Mode Entry Sequencer

This block sits on the host side of a serial programming link and brings a target device into its program/verify mode. It drives three lines toward the target: the reset/programming-voltage enable (`rst_line_o`), the serial clock (`sclk_o`) and the serial data line (`sdat_o`). When software or a higher-level controller raises `start_i`, the block runs a fixed sequence with no further input:

1. It gives the reset line a short high pulse and then drops it.
2. It waits a guard interval.
3. It clocks a fixed 32-bit entry key out on the data line, most significant bit first.
4. After a short raise delay, it drives the reset line high again and holds it there.
5. It waits the settle time and then raises `ready_o`.

Every interval is a parameter counted in clock cycles, and so is the serial clock half-period. The mode stays in force while `ready_o` is high. An `exit_i` request drops the reset line and returns the block to idle.

The controller is a single state machine. Its states are IDLE, PULSE, GUARD, SHIFT, RAISE, SETTLE and READY. Its transitions are:
- IDLE→PULSE when start is sampled.
- PULSE→GUARD when the pulse timer expires.
- GUARD→SHIFT when the guard timer expires.
- SHIFT→RAISE after the last key bit.
- RAISE→SETTLE when the raise timer expires.
- SETTLE→READY when the settle timer expires.
- READY→IDLE when exit is sampled.

One shared down-counter times every interval. A separate serializer produces the key bits and the serial clock.

Top module: `prog_entry_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, `rst_line_o`, `sclk_o`, `sdat_o`, `busy_o` and `ready_o` are all 0.
- R2: A `start_i` sampled high in idle makes `rst_line_o` high from the next cycle on, for exactly PULSE_CYC cycles, with `busy_o` high.
- R3: After the pulse, `rst_line_o`, `sclk_o` and `sdat_o` stay low for exactly GUARD_CYC cycles before the first key bit appears.
- R4: Each key bit occupies 2*HALF_CYC cycles: HALF_CYC cycles with `sclk_o` low, then HALF_CYC cycles with `sclk_o` high. `sdat_o` holds the bit for the whole of that time, so it changes only while `sclk_o` is low. `sclk_o` is low outside the key.
- R5: The key is KEY_W = 32 bits of KEY (default 32'h4D434851), sent from bit 31 down to bit 0. A sampler that reads `sdat_o` on each rising `sclk_o` rebuilds KEY.
- R6: After the last bit, all lines stay low for exactly RAISE_CYC cycles, and then `rst_line_o` rises.
- R7: `rst_line_o` stays high with `sclk_o` and `sdat_o` low for exactly SETTLE_A_CYC + SETTLE_B_CYC cycles before `ready_o` rises.
- R8: `ready_o` and `rst_line_o` stay high until `exit_i` is sampled high. In the next cycle both are low and the block is idle.
- R9: `busy_o` is high from the cycle after start is accepted until `ready_o` rises. It is never high together with `ready_o`. A `start_i` outside idle has no effect on any output.
- R10: An `exit_i` outside the READY state has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the entry sequence (acted on only in idle) |
| exit_i | input | 1 | Request to leave the mode (acted on only in READY) |
| rst_line_o | output | 1 | Reset/programming-voltage enable to the target |
| sclk_o | output | 1 | Serial clock to the target, idles low |
| sdat_o | output | 1 | Serial data to the target |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Target is in program/verify mode |

## Verification
The bench builds the block with small intervals:
- PULSE_CYC=2, GUARD_CYC=3, HALF_CYC=2
- RAISE_CYC=2, SETTLE_A_CYC=3, SETTLE_B_CYC=2

A whole entry therefore takes about 140 cycles. Several entries fit in one run, and every interval boundary and each of the 64 serial clock edges is compared cycle by cycle against the model. HALF_CYC=2 makes the half-period counter wrap inside each phase, which a value of 1 would hide. Unequal settle parts show whether the two settle intervals are really summed. Stray start and exit requests are placed in the middle of the key shift and inside READY.

// File: rtl/pes_pkg.sv
package pes_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_GUARD,
        ST_SHIFT,
        ST_RAISE,
        ST_SETTLE,
        ST_READY
    } pes_state_e;

    localparam logic [31:0] PES_ENTRY_KEY = 32'h4D434851;

    function automatic int unsigned pes_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pes_interval.sv
// Shared down-counter: loaded on entry to a timed state, done when it reaches zero.
module pes_interval #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pes_serializer.sv
// Shifts KEY out MSB first; each bit spends HALF_CYC cycles with the clock low, then HALF_CYC high.
module pes_serializer #(
    parameter int unsigned      KEY_W    = 32,
    parameter logic [KEY_W-1:0] KEY      = '0,
    parameter int unsigned      HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic sclk_o,
    output logic sdat_o,
    output logic last_o
);

    localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int unsigned BW = (KEY_W > 1) ? $clog2(KEY_W) : 1;

    logic             active_q;
    logic             phase_q;   // 0: clock low, 1: clock high
    logic [HW-1:0]    half_q;
    logic [BW-1:0]    bits_q;
    logic [KEY_W-1:0] shreg_q;
    logic             half_end;

    assign half_end = (half_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            half_q   <= '0;
            bits_q   <= '0;
            shreg_q  <= '0;
        end else if (go_i) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            half_q   <= HW'(HALF_CYC - 1);
            bits_q   <= BW'(KEY_W - 1);
            shreg_q  <= KEY;
        end else if (active_q) begin
            if (!half_end) begin
                half_q <= half_q - 1'b1;
            end else begin
                half_q <= HW'(HALF_CYC - 1);
                if (!phase_q) begin
                    phase_q <= 1'b1;
                end else begin
                    phase_q <= 1'b0;
                    if (bits_q == '0) begin
                        active_q <= 1'b0;
                    end else begin
                        bits_q  <= bits_q - 1'b1;
                        shreg_q <= {shreg_q[KEY_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sclk_o = active_q & phase_q;
    assign sdat_o = active_q & shreg_q[KEY_W-1];
    assign last_o = active_q & phase_q & half_end & (bits_q == '0);

endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
    import pes_pkg::*;
#(
    parameter int unsigned      KEY_W        = 32,
    parameter logic [KEY_W-1:0] KEY          = PES_ENTRY_KEY,
    parameter int unsigned      PULSE_CYC    = 8,
    parameter int unsigned      GUARD_CYC    = 20,
    parameter int unsigned      HALF_CYC     = 10,
    parameter int unsigned      RAISE_CYC    = 4,
    parameter int unsigned      SETTLE_A_CYC = 500,
    parameter int unsigned      SETTLE_B_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic exit_i,
    output logic rst_line_o,
    output logic sclk_o,
    output logic sdat_o,
    output logic busy_o,
    output logic ready_o
);

    localparam int unsigned SETTLE_CYC = SETTLE_A_CYC + SETTLE_B_CYC;
    localparam int unsigned MAX_CYC    = pes_max(pes_max(PULSE_CYC, GUARD_CYC),
                                                 pes_max(RAISE_CYC, SETTLE_CYC));
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    pes_state_e       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             ser_go;
    logic             ser_last;
    logic             ser_sclk;
    logic             ser_sdat;

    pes_interval #(
        .CNT_W (CNT_W)
    ) u_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    pes_serializer #(
        .KEY_W    (KEY_W),
        .KEY      (KEY),
        .HALF_CYC (HALF_CYC)
    ) u_serializer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (ser_go),
        .sclk_o (ser_sclk),
        .sdat_o (ser_sdat),
        .last_o (ser_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and interval loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ser_go   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    state_d  = ST_GUARD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(GUARD_CYC - 1);
                end
            end
            ST_GUARD: begin
                if (tmr_done) begin
                    state_d = ST_SHIFT;
                    ser_go  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (ser_last) begin
                    state_d  = ST_RAISE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RAISE_CYC - 1);
                end
            end
            ST_RAISE: begin
                if (tmr_done) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETTLE_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                if (exit_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rst_line_o = 1'b0;
        busy_o     = 1'b0;
        ready_o    = 1'b0;
        sclk_o     = 1'b0;
        sdat_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PULSE:  begin rst_line_o = 1'b1; busy_o = 1'b1; end
            ST_GUARD:  busy_o = 1'b1;
            ST_SHIFT:  begin busy_o = 1'b1; sclk_o = ser_sclk; sdat_o = ser_sdat; end
            ST_RAISE:  busy_o = 1'b1;
            ST_SETTLE: begin rst_line_o = 1'b1; busy_o = 1'b1; end
            ST_READY:  begin rst_line_o = 1'b1; ready_o = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/pes_chk.sv
module pes_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic exit_i,
    input logic rst_line_o,
    input logic sclk_o,
    input logic sdat_o,
    input logic busy_o,
    input logic ready_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !ready_o) |-> (!rst_line_o && !sclk_o && !sdat_o)); // R1

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !ready_o && start_i) |=> (busy_o && rst_line_o)); // R2

    AST_DATA_HELD_HIGH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdat_o)); // R4

    AST_SCLK_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (busy_o && !rst_line_o)); // R4

    AST_READY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> rst_line_o); // R8

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !exit_i) |=> ready_o); // R8

    AST_EXIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && exit_i) |=> (!ready_o && !rst_line_o && !busy_o)); // R8

    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && ready_o)); // R9

    AST_BUSY_ENDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ready_o); // R9

endmodule

bind prog_entry_seq pes_chk u_pes_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .exit_i     (exit_i),
    .rst_line_o (rst_line_o),
    .sclk_o     (sclk_o),
    .sdat_o     (sdat_o),
    .busy_o     (busy_o),
    .ready_o    (ready_o)
);

// File: tb/prog_entry_seq_bench.sv
`timescale 1ns/100ps
module prog_entry_seq_bench;

    localparam int P_PULSE  = 2;
    localparam int P_GUARD  = 3;
    localparam int P_HALF   = 2;
    localparam int P_RAISE  = 2;
    localparam int P_SET_A  = 3;
    localparam int P_SET_B  = 2;
    localparam logic [31:0] EXP_KEY = 32'h4D434851;

    logic clk = 1'b0;
    logic rst_n, start_i, exit_i;
    logic rst_line_o, sclk_o, sdat_o, busy_o, ready_o;

    always #2.5 clk = ~clk;

    prog_entry_seq #(
        .PULSE_CYC    (P_PULSE),
        .GUARD_CYC    (P_GUARD),
        .HALF_CYC     (P_HALF),
        .RAISE_CYC    (P_RAISE),
        .SETTLE_A_CYC (P_SET_A),
        .SETTLE_B_CYC (P_SET_B)
    ) u_prog_entry_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .exit_i     (exit_i),
        .rst_line_o (rst_line_o),
        .sclk_o     (sclk_o),
        .sdat_o     (sdat_o),
        .busy_o     (busy_o),
        .ready_o    (ready_o)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Reference model: expected {rst_line, sclk, sdat, busy, ready} per cycle
    logic [4:0] exp_v = '0;
    string      exp_tag = "R1";
    logic [4:0] q[$];
    string      tq[$];
    int         m_phase = 0;   // 0 idle, 1 sequence, 2 in mode

    task automatic push_n(input int n, input logic [4:0] v, input string t);
        for (int i = 0; i < n; i++) begin
            q.push_back(v);
            tq.push_back(t);
        end
    endtask

    task automatic build_seq();
        push_n(P_PULSE, 5'b10010, "R2");
        push_n(P_GUARD, 5'b00010, "R3");
        for (int b = 31; b >= 0; b--) begin
            push_n(P_HALF, {2'b00, EXP_KEY[b], 2'b10}, "R4");
            push_n(P_HALF, {2'b01, EXP_KEY[b], 2'b10}, "R5");
        end
        push_n(P_RAISE, 5'b00010, "R6");
        push_n(P_SET_A + P_SET_B, 5'b10010, "R7");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            tq.delete();
            m_phase = 0;
            exp_v   = '0;
            exp_tag = "R1";
        end else begin
            case (m_phase)
                0: begin
                    if (start_i) begin
                        build_seq();
                        exp_v   = q.pop_front();
                        exp_tag = tq.pop_front();
                        m_phase = 1;
                    end else begin
                        exp_v   = '0;
                        exp_tag = "R1";
                    end
                end
                1: begin
                    if (q.size() > 0) begin
                        exp_v   = q.pop_front();
                        exp_tag = tq.pop_front();
                    end else begin
                        m_phase = 2;
                        exp_v   = 5'b10001;
                        exp_tag = "R8";
                    end
                end
                default: begin
                    if (exit_i) begin
                        m_phase = 0;
                        exp_v   = '0;
                    end else begin
                        exp_v   = 5'b10001;
                    end
                    exp_tag = "R8";
                end
            endcase
        end
    end

    // Per-cycle comparison and key capture on rising serial clock
    logic [31:0] cap = '0;
    int          nbits = 0;
    logic        prev_sclk = 1'b0;

    always @(negedge clk) begin
        logic [4:0] act;
        act = {rst_line_o, sclk_o, sdat_o, busy_o, ready_o};
        check(act === exp_v, exp_tag, {27'd0, act}, {27'd0, exp_v});
        if (sclk_o && !prev_sclk) begin
            cap = {cap[30:0], sdat_o};
            nbits++;
        end
        prev_sclk = sclk_o;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic wait_ready();
        int t = 0;
        while (!ready_o && t < 1000) begin
            @(negedge clk);
            t++;
        end
        check(ready_o === 1'b1, "R7", {31'd0, ready_o}, 32'd1);
    endtask

    task automatic check_key();
        check(cap === EXP_KEY, "R5", cap, EXP_KEY);
        check(nbits == 32, "R5", nbits, 32);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R8 watchdog expired: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        start_i = 1'b0;
        exit_i  = 1'b0;
        repeat (3) @(negedge clk);
        check({rst_line_o, sclk_o, sdat_o, busy_o, ready_o} === 5'b0, "R1",
              {27'd0, rst_line_o, sclk_o, sdat_o, busy_o, ready_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Run 1: one-cycle start, stray start/exit during the key shift
        cap = '0; nbits = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        start_i = 1'b1;
        exit_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        exit_i  = 1'b0;
        check(busy_o === 1'b1 && ready_o === 1'b0, "R9", {30'd0, busy_o, ready_o}, 32'd2);
        check(rst_line_o === 1'b0, "R10", {31'd0, rst_line_o}, 32'd0);
        wait_ready();
        check_key();

        // Start while in the mode is ignored
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(ready_o === 1'b1 && busy_o === 1'b0, "R9", {30'd0, ready_o, busy_o}, 32'd2);
        repeat (4) @(negedge clk);
        exit_i = 1'b1;
        @(negedge clk);
        exit_i = 1'b0;
        check(ready_o === 1'b0 && rst_line_o === 1'b0, "R8", {30'd0, ready_o, rst_line_o}, 32'd0);
        repeat (5) @(negedge clk);

        // Run 2: start held for several cycles
        cap = '0; nbits = 0;
        start_i = 1'b1;
        repeat (4) @(negedge clk);
        start_i = 1'b0;
        wait_ready();
        check_key();
        repeat (2) @(negedge clk);
        exit_i = 1'b1;
        @(negedge clk);
        exit_i = 1'b0;
        check(busy_o === 1'b0 && ready_o === 1'b0, "R8", {30'd0, busy_o, ready_o}, 32'd0);
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end

endmodule